// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps large, aligned regions of a 32-bit effective address space onto physical memory using a small set of entries. Each entry is a pair of 32-bit registers. The upper register holds the effective block index, a block-length mask and one valid bit for each privilege level. The lower register holds the physical block index, four cache attribute bits and a two-bit protection code. Software loads the entries through a one-word write port. The lower or upper register is chosen by a select bit.

Each cycle, a lookup port presents an effective address, a privilege flag and an access kind. One clock edge later the unit reports four results: whether an entry matched, the physical address, the cache attributes, and whether the access breaks the entry's protection. The block-length mask widens the block from 128 KB up to 256 MB. Each mask bit that is set removes one effective address bit from the compare. That same address bit is then passed straight through into the physical address.

Top module: `bat_xlate`

## Requirements
- R1: After a synchronous reset, every entry is invalid and all result outputs read zero. Until software writes an entry, every lookup misses.
- R2: Upper register layout: bits 31:17 hold the effective block index, bits 12:2 the block-length mask, bit 1 the supervisor-valid bit and bit 0 the user-valid bit. Bits 16:13 are ignored.
- R3: Lower register layout: bits 31:17 hold the physical block index and bit 7 write-through. Bit 6 is cache-inhibit, bit 5 coherence, bit 4 guarded, and bits 1:0 the protection code. The other bits are ignored.
- R4: Mask bit k (0..10) covers effective address bit 17+k. An entry matches when all uncovered bits of address bits 31:17 equal its effective index. Mask 0x000 gives a 128 KB block, and each extra low one-bit doubles it, up to 0x7FF for 256 MB.
- R5: On a hit, address bits 16:0 pass through unchanged. Each covered bit in 31:17 is taken from the effective address, and each uncovered bit comes from the physical block index.
- R6: A supervisor lookup (privilege flag 1) can match an entry only if its supervisor-valid bit is set. A user lookup (flag 0) can match only if the user-valid bit is set.
- R7: Access kinds are 00 load, 01 store, 10 instruction fetch, and 11, which acts as a load. Protection code 00 faults on every access. Codes 01 and 11 fault only on a store. Code 10 never faults.
- R8: On a hit, the attribute output is {write-through, inhibit, coherence, guarded} from the matching entry, in bits 3:0. For an instruction fetch, the guarded bit is always reported as 0.
- R9: When several entries match, the lowest-numbered entry supplies the result.
- R10: On a miss, the hit, fault, address and attribute outputs are all zero.
- R11: Results are registered. They reflect the lookup inputs present at the previous rising clock edge. A register write becomes visible to lookups sampled at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Entry number to write |
| wr_lower | input | 1 | 1 selects the lower register, 0 the upper |
| wr_data | input | 32 | Register write data |
| lk_ea | input | 32 | Effective address to translate |
| lk_super | input | 1 | 1 for supervisor privilege, 0 for user |
| lk_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| res_hit | output | 1 | An entry matched |
| res_pa | output | 32 | Physical address |
| res_attr | output | 4 | {write-through, inhibit, coherence, guarded} |
| res_fault | output | 1 | Protection fault on a matching entry |

## Verification
The assertions assume that the lookup inputs are held stable around each clock edge. They also assume that the result registers compare the outputs with the inputs sampled one edge earlier. A write in the same cycle as a lookup does not disturb that relation. The stimulus drives all inputs on the falling edge only. It keeps the access kind among the four defined codes. The mask values it writes are either contiguous low ones, to cover every block size, or arbitrary patterns in the random phase. Both kinds fit the per-bit rule in R4 and R5.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 17;
    localparam int BIX_W  = ADDR_W - OFS_W;
    localparam int MASK_W = 11;
    localparam int ATTR_W = 4;

    typedef struct packed {
        logic [BIX_W-1:0]  ebi;
        logic [3:0]        rsv;
        logic [MASK_W-1:0] len_mask;
        logic              sup_ok;
        logic              usr_ok;
    } bat_upper_t;

    typedef struct packed {
        logic wt;
        logic ci;
        logic coh;
        logic grd;
    } cache_attr_t;

    typedef enum logic [1:0] {
        PROT_NONE = 2'b00,
        PROT_RO   = 2'b01,
        PROT_RW   = 2'b10,
        PROT_RO_X = 2'b11
    } prot_t;

    typedef struct packed {
        logic [BIX_W-1:0] pbi;
        logic [8:0]       rsv_hi;
        cache_attr_t      attr;
        logic [1:0]       rsv_lo;
        prot_t            prot;
    } bat_lower_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } acc_kind_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] pa;
        cache_attr_t       attr;
        logic              fault;
    } xlate_res_t;

    function automatic logic [BIX_W-1:0] widen_mask(input logic [MASK_W-1:0] m);
        return {{(BIX_W-MASK_W){1'b0}}, m};
    endfunction

    function automatic logic prot_fault(input prot_t p, input acc_kind_t k);
        case (p)
            PROT_NONE: return 1'b1;
            PROT_RW:   return 1'b0;
            default:   return (k == ACC_STORE);
        endcase
    endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic                          wr_lower,
    input  logic [ADDR_W-1:0]             wr_data,
    output bat_upper_t [NUM_ENT-1:0]      upr,
    output bat_lower_t [NUM_ENT-1:0]      lwr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                upr[i] <= '0;
                lwr[i] <= '0;
            end
        end else if (wr_en && (32'(wr_idx) < NUM_ENT)) begin
            if (wr_lower)
                lwr[wr_idx] <= bat_lower_t'(wr_data);
            else
                upr[wr_idx] <= bat_upper_t'(wr_data);
        end
    end

endmodule

// File: rtl/bat_match.sv
module bat_match
    import bat_pkg::*;
(
    input  bat_upper_t       ent,
    input  logic [BIX_W-1:0] ea_bix,
    input  logic             sup,
    output logic             hit,
    output logic [BIX_W-1:0] pass_mask
);

    logic priv_ok;
    logic unused_rsv;

    assign unused_rsv = ^ent.rsv;
    assign pass_mask  = widen_mask(ent.len_mask);
    assign priv_ok    = sup ? ent.sup_ok : ent.usr_ok;
    assign hit        = priv_ok && (((ea_bix ^ ent.ebi) & ~pass_mask) == '0);

endmodule

// File: rtl/bat_select.sv
module bat_select
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  logic [NUM_ENT-1:0]              hit_vec,
    input  bat_lower_t [NUM_ENT-1:0]        lwr,
    input  logic [NUM_ENT-1:0][BIX_W-1:0]   pmask,
    input  logic [ADDR_W-1:0]               ea,
    input  acc_kind_t                       kind,
    output xlate_res_t                      res
);

    logic [NUM_ENT-1:0] unused_rsv;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_sink
        assign unused_rsv[g] = ^{lwr[g].rsv_hi, lwr[g].rsv_lo};
    end

    always_comb begin
        logic found;
        found = 1'b0;
        res   = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!found && hit_vec[i]) begin
                found     = 1'b1;
                res.hit   = 1'b1;
                res.pa    = {(lwr[i].pbi & ~pmask[i]) | (ea[ADDR_W-1:OFS_W] & pmask[i]),
                             ea[OFS_W-1:0]};
                res.attr  = lwr[i].attr;
                if (kind == ACC_FETCH)
                    res.attr.grd = 1'b0;
                res.fault = prot_fault(lwr[i].prot, kind);
            end
        end
    end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_idx,
    input  logic        wr_lower,
    input  logic [31:0] wr_data,
    input  logic [31:0] lk_ea,
    input  logic        lk_super,
    input  logic [1:0]  lk_kind,
    output logic        res_hit,
    output logic [31:0] res_pa,
    output logic [3:0]  res_attr,
    output logic        res_fault
);

    localparam int NUM_ENT = 4;

    bat_upper_t [NUM_ENT-1:0]            upr;
    bat_lower_t [NUM_ENT-1:0]            lwr;
    logic [NUM_ENT-1:0]                  hit_vec;
    logic [NUM_ENT-1:0][BIX_W-1:0]       pmask;
    xlate_res_t                          res_d;
    xlate_res_t                          res_q;

    bat_regfile #(.NUM_ENT(NUM_ENT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_lower (wr_lower),
        .wr_data  (wr_data),
        .upr      (upr),
        .lwr      (lwr)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        bat_match u_match (
            .ent       (upr[g]),
            .ea_bix    (lk_ea[ADDR_W-1:OFS_W]),
            .sup       (lk_super),
            .hit       (hit_vec[g]),
            .pass_mask (pmask[g])
        );
    end

    bat_select #(.NUM_ENT(NUM_ENT)) u_sel (
        .hit_vec (hit_vec),
        .lwr     (lwr),
        .pmask   (pmask),
        .ea      (lk_ea),
        .kind    (acc_kind_t'(lk_kind)),
        .res     (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign res_hit   = res_q.hit;
    assign res_pa    = res_q.pa;
    assign res_attr  = res_q.attr;
    assign res_fault = res_q.fault;

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] lk_ea,
    input logic [1:0]  lk_kind,
    input logic        res_hit,
    input logic [31:0] res_pa,
    input logic [3:0]  res_attr,
    input logic        res_fault
);

    // R10
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> (!res_fault && res_pa == 32'd0 && res_attr == 4'd0));

    // R5
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (res_pa[16:0] == $past(lk_ea[16:0])));

    // R8
    fetch_unguarded_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(lk_kind) == 2'b10 && res_hit) |-> !res_attr[0]);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_hit && !res_fault));

    // R7
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        res_fault |-> res_hit);

endmodule

bind bat_xlate bat_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_ea     (lk_ea),
    .lk_kind   (lk_kind),
    .res_hit   (res_hit),
    .res_pa    (res_pa),
    .res_attr  (res_attr),
    .res_fault (res_fault)
);

// File: tb/sim_bat_xlate.sv
module sim_bat_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_idx;
    logic        wr_lower;
    logic [31:0] wr_data;
    logic [31:0] lk_ea;
    logic        lk_super;
    logic [1:0]  lk_kind;
    logic        res_hit;
    logic [31:0] res_pa;
    logic [3:0]  res_attr;
    logic        res_fault;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] up_m [4];
    logic [31:0] lo_m [4];

    always #5 clk = ~clk;

    bat_xlate u0 (.*);

    function automatic logic [37:0] model(input logic [31:0] ea, input logic sup,
                                          input logic [1:0] kind);
        logic [37:0] r;
        r = '0;
        for (int i = 3; i >= 0; i--) begin
            logic [14:0] m;
            logic        v;
            m = {4'b0, up_m[i][12:2]};
            v = sup ? up_m[i][1] : up_m[i][0];
            if (v && (((ea[31:17] ^ up_m[i][31:17]) & ~m) == 15'd0)) begin
                logic [3:0] at;
                logic       f;
                at = lo_m[i][7:4];
                if (kind == 2'b10) at[0] = 1'b0;
                case (lo_m[i][1:0])
                    2'b00:   f = 1'b1;
                    2'b10:   f = 1'b0;
                    default: f = (kind == 2'b01);
                endcase
                r = {1'b1, (lo_m[i][31:17] & ~m) | (ea[31:17] & m), ea[16:0], at, f};
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [37:0] exp);
        logic [37:0] got;
        got = {res_hit, res_pa, res_attr, res_fault};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b pa=%08h attr=%0h fault=%0b expected hit=%0b pa=%08h attr=%0h fault=%0b",
                     req, got[37], got[36:5], got[4:1], got[0], exp[37], exp[36:5], exp[4:1], exp[0]);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic low, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_lower = low; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (low) lo_m[idx] = d; else up_m[idx] = d;
    endtask

    task automatic look(input string req, input logic [31:0] ea, input logic sup,
                        input logic [1:0] kind);
        @(negedge clk);
        lk_ea = ea; lk_super = sup; lk_kind = kind;
        @(negedge clk);
        check(req, model(ea, sup, kind));
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) begin
            wr(2'(i), 1'b0, 32'd0);
            wr(2'(i), 1'b1, 32'd0);
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 4; i++) begin up_m[i] = '0; lo_m[i] = '0; end
        wr_en = 0; wr_idx = 0; wr_lower = 0; wr_data = 0;
        lk_ea = 32'h0002_0000; lk_super = 1; lk_kind = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs zero right after reset
        check("R1", 38'd0);
        rst = 1'b0;
        look("R1", 32'h0000_0000, 1'b1, 2'b00);
        look("R1", 32'hFFFF_FFFF, 1'b0, 2'b01);

        // R4 R5 R2: every block size, inside and just outside
        for (int m = 0; m <= 11; m++) begin
            logic [10:0] mk;
            logic [14:0] eb, in_flip, out_flip;
            mk = 11'((32'd1 << m) - 1);
            eb = 15'h6D35;
            wr(2'd0, 1'b0, {eb, 4'hF, mk, 2'b11});
            wr(2'd0, 1'b1, {15'h1234, 9'h0, 4'b1010, 2'b00, 2'b10});
            in_flip  = (m > 0) ? 15'(32'd1 << (m - 1)) : 15'd0;
            out_flip = 15'(32'd1 << m);
            look("R4", {eb ^ in_flip, 17'h0ABCD}, 1'b1, 2'b00);
            if (!res_hit) begin n_fail++; $display("FAIL R4: got hit=0 expected hit=1 mask=%03h", mk); end
            n_chk++;
            look("R5", {eb ^ {4'b0, mk}, 17'h1F0F0}, 1'b0, 2'b00);
            look("R4", {eb ^ out_flip, 17'h00001}, 1'b1, 2'b00);
            if (res_hit) begin n_fail++; $display("FAIL R4: got hit=1 expected hit=0 mask=%03h", mk); end
            n_chk++;
        end

        // R6: privilege gating
        clear_all();
        wr(2'd1, 1'b1, {15'h0400, 9'h1FF, 4'b0000, 2'b11, 2'b10});
        wr(2'd1, 1'b0, {15'h0100, 4'h0, 11'h000, 2'b10});
        look("R6", 32'h0200_0040, 1'b1, 2'b00);
        look("R6", 32'h0200_0040, 1'b0, 2'b00);
        wr(2'd1, 1'b0, {15'h0100, 4'h0, 11'h000, 2'b01});
        look("R6", 32'h0200_0040, 1'b1, 2'b00);
        look("R6", 32'h0200_0040, 1'b0, 2'b00);

        // R7 R3: every protection code and access kind
        wr(2'd1, 1'b0, {15'h0100, 4'h0, 11'h000, 2'b11});
        for (int p = 0; p < 4; p++) begin
            wr(2'd1, 1'b1, {15'h0400, 9'h0, 4'b0000, 2'b00, 2'(p)});
            for (int k = 0; k < 4; k++) look("R7", 32'h0201_2345, 1'b1, 2'(k));
        end

        // R8: attributes, guarded hidden on fetch
        wr(2'd1, 1'b1, {15'h0400, 9'h0, 4'b1111, 2'b00, 2'b10});
        look("R8", 32'h0200_0000, 1'b0, 2'b00);
        look("R8", 32'h0200_0000, 1'b0, 2'b10);
        wr(2'd1, 1'b1, {15'h0400, 9'h0, 4'b0101, 2'b11, 2'b10});
        look("R3", 32'h0200_0000, 1'b0, 2'b01);

        // R9: overlap, lowest wins
        wr(2'd2, 1'b0, {15'h0100, 4'h0, 11'h7FF, 2'b11});
        wr(2'd2, 1'b1, {15'h7000, 9'h0, 4'b1000, 2'b00, 2'b01});
        look("R9", 32'h0201_0000, 1'b1, 2'b01);
        wr(2'd1, 1'b0, 32'd0);
        look("R9", 32'h0201_0000, 1'b1, 2'b01);

        // R10: miss outputs zero
        look("R10", 32'h8000_0000, 1'b1, 2'b01);

        // R11: output holds until the next edge
        @(negedge clk);
        lk_ea = 32'h0201_0000; lk_super = 1; lk_kind = 0;
        @(negedge clk);
        lk_ea = 32'hF000_0000;
        #1;
        check("R11", model(32'h0201_0000, 1'b1, 2'b00));
        @(negedge clk);
        check("R11", model(32'hF000_0000, 1'b1, 2'b00));

        // random phase
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 4; i++) begin
                logic [31:0] u;
                u = $urandom;
                if (u[20]) u[12:2] = 11'((32'd1 << (u[27:24] % 12)) - 1);
                wr(2'(i), 1'b0, u);
                wr(2'(i), 1'b1, $urandom);
            end
            for (int n = 0; n < 150; n++) begin
                logic [31:0] ea, pick;
                pick = $urandom;
                ea = $urandom;
                if (pick[1:0] != 2'b00) ea[31:17] = up_m[pick[3:2]][31:17] ^ 15'(pick[15:4] & 12'h7FF);
                look(ea[31:17] == up_m[pick[3:2]][31:17] ? "R4" : "R5", ea, pick[16], pick[18:17]);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule